// File: doc/BRIEF.md
# Machine Trap Entry and Return Sequencer

This block carries out the machine-level state changes when a trap is taken or a return-from-trap executes. When a trap request arrives, it saves the interrupted PC and records the cause. It pushes the interrupt-enable bit and the prior privilege onto a one-deep stack held in the status fields. It then computes the handler address from the trap-vector register and raises a one-cycle redirect with the new PC and machine privilege.

When a return strobe arrives instead, the block pops that stack. It redirects to the saved PC at the stacked privilege. The choice of which trap to take, delegation and exception detection all happen upstream. This block only sequences the architectural updates. All of its outputs are registered, so every effect appears one clock after the request.

Top module: `mtrap_seq`

## Requirements
- R1: On an accepted trap, the saved PC output takes the current PC with bits [1:0] forced to 0. Bits [1:0] of the saved PC are always zero.
- R2: On an accepted trap, the cause output holds the interrupt flag in bit XLEN-1, zeros in the middle bits, and the cause code in bits [CODE_W-1:0].
- R3: On an accepted trap, the previous-privilege field takes the current privilege input and the privilege output becomes machine. Privilege encoding: 00 user, 01 supervisor, 11 machine.
- R4: On an accepted trap, the previous-enable bit takes the old enable bit, and the enable bit becomes 0.
- R5: When trap-vector bits [1:0] are 00, 10 or 11, the redirect PC is the vector base, which is trap-vector with bits [1:0] cleared.
- R6: When trap-vector bits [1:0] are 01, an interrupt redirects to base + 4 × code, and a synchronous exception redirects to base.
- R7: On an accepted return, the redirect PC is the saved PC, and the privilege output becomes the previous-privilege field.
- R8: On an accepted return, the enable bit takes the previous-enable bit, the previous-enable bit becomes 1, and the previous-privilege field becomes 00 (user).
- R9: When a trap request and a return strobe arrive in the same cycle, only the trap is performed and the return has no effect.
- R10: Redirect is high for exactly the cycle after an accepted trap or return. Reset (synchronous, active high) gives redirect 0, enable 0, previous-enable 0, previous-privilege 00, saved PC 0, cause 0, next PC 0 and privilege 11.
- R11: In a cycle with neither request, all state outputs hold their values and redirect is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_req | input | 1 | Take a trap this cycle |
| trap_irq | input | 1 | Trap is an interrupt (1) or a synchronous exception (0) |
| trap_code | input | CODE_W | Cause code |
| cur_pc | input | XLEN | PC of the interrupted instruction |
| cur_priv | input | 2 | Privilege level in effect before the trap |
| mret | input | 1 | Return-from-trap strobe |
| tvec | input | XLEN | Trap-vector register: base in [XLEN-1:2], mode in [1:0] |
| redirect_o | output | 1 | Next PC valid for one cycle |
| next_pc_o | output | XLEN | Handler address or return address |
| priv_o | output | 2 | Privilege level after the event |
| epc_o | output | XLEN | Saved exception PC |
| cause_o | output | XLEN | Recorded cause |
| ie_o | output | 1 | Global machine interrupt enable |
| pie_o | output | 1 | Stacked previous interrupt enable |
| pp_o | output | 2 | Stacked previous privilege |

## Verification
Out of reset the enable bit is 0, and only returns can raise it. Seeing a trap push a 1 into the previous-enable bit therefore needs two returns first: the first sets previous-enable, and the second moves it into enable. The stimulus opens with that pair of returns. It then runs a trap with a return in the same cycle, to show the return is dropped and the stack is not popped. Vectored traps with code 0, a middle code and the largest code, plus an exception in vectored mode, cover the offset adder and its bypass.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;
  typedef enum logic [1:0] {
    PRIV_U = 2'b00,
    PRIV_S = 2'b01,
    PRIV_M = 2'b11
  } priv_e;

  localparam logic [1:0] VEC_DIRECT   = 2'b00;
  localparam logic [1:0] VEC_VECTORED = 2'b01;
endpackage

// File: rtl/mtrap_vec.sv
module mtrap_vec #(
  parameter int XLEN   = 32,
  parameter int CODE_W = 5
) (
  input  logic [XLEN-1:0]   tvec,
  input  logic              is_irq,
  input  logic [CODE_W-1:0] code,
  output logic [XLEN-1:0]   target
);
  import mtrap_pkg::*;

  localparam int PAD_W = XLEN - CODE_W - 2;

  logic [XLEN-1:0] base;
  logic [XLEN-1:0] offset;

  assign base   = {tvec[XLEN-1:2], 2'b00};
  assign offset = {{PAD_W{1'b0}}, code, 2'b00};

  always_comb begin
    if (tvec[1:0] == VEC_VECTORED && is_irq)
      target = base + offset;
    else
      target = base;
  end
endmodule

// File: rtl/mtrap_csr.sv
module mtrap_csr #(
  parameter int XLEN   = 32,
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take_trap,
  input  logic              take_ret,
  input  logic              is_irq,
  input  logic [CODE_W-1:0] code,
  input  logic [XLEN-1:0]   pc,
  input  logic [1:0]        priv_in,
  output logic [XLEN-1:0]   epc_q,
  output logic [XLEN-1:0]   cause_q,
  output logic              ie_q,
  output logic              pie_q,
  output logic [1:0]        pp_q
);
  import mtrap_pkg::*;

  localparam int MID_W = XLEN - CODE_W - 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      epc_q   <= '0;
      cause_q <= '0;
      ie_q    <= 1'b0;
      pie_q   <= 1'b0;
      pp_q    <= PRIV_U;
    end else if (take_trap) begin
      epc_q   <= {pc[XLEN-1:2], 2'b00};
      cause_q <= {is_irq, {MID_W{1'b0}}, code};
      pie_q   <= ie_q;
      ie_q    <= 1'b0;
      pp_q    <= priv_in;
    end else if (take_ret) begin
      ie_q    <= pie_q;
      pie_q   <= 1'b1;
      pp_q    <= PRIV_U;
    end
  end

  // R4
  ie_cleared_chk: assert property (@(posedge clk) disable iff (rst)
    take_trap |=> !ie_q);

  // R4
  pie_push_chk: assert property (@(posedge clk) disable iff (rst)
    take_trap |=> pie_q == $past(ie_q));

  // R8
  pop_chk: assert property (@(posedge clk) disable iff (rst)
    take_ret && !take_trap |=> pie_q && pp_q == PRIV_U && ie_q == $past(pie_q));

  // R1
  epc_align_chk: assert property (@(posedge clk) disable iff (rst)
    epc_q[1:0] == 2'b00);

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !take_trap && !take_ret |=> $stable(epc_q) && $stable(cause_q) && $stable(pp_q));
endmodule

// File: rtl/mtrap_seq.sv
module mtrap_seq #(
  parameter int XLEN   = 32,
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trap_req,
  input  logic              trap_irq,
  input  logic [CODE_W-1:0] trap_code,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [1:0]        cur_priv,
  input  logic              mret,
  input  logic [XLEN-1:0]   tvec,
  output logic              redirect_o,
  output logic [XLEN-1:0]   next_pc_o,
  output logic [1:0]        priv_o,
  output logic [XLEN-1:0]   epc_o,
  output logic [XLEN-1:0]   cause_o,
  output logic              ie_o,
  output logic              pie_o,
  output logic [1:0]        pp_o
);
  import mtrap_pkg::*;

  logic            take_trap;
  logic            take_ret;
  logic [XLEN-1:0] handler_pc;

  assign take_trap = trap_req;
  assign take_ret  = mret & ~trap_req;

  mtrap_vec #(.XLEN(XLEN), .CODE_W(CODE_W)) u_vec (
    .tvec   (tvec),
    .is_irq (trap_irq),
    .code   (trap_code),
    .target (handler_pc)
  );

  mtrap_csr #(.XLEN(XLEN), .CODE_W(CODE_W)) u_csr (
    .clk       (clk),
    .rst       (rst),
    .take_trap (take_trap),
    .take_ret  (take_ret),
    .is_irq    (trap_irq),
    .code      (trap_code),
    .pc        (cur_pc),
    .priv_in   (cur_priv),
    .epc_q     (epc_o),
    .cause_q   (cause_o),
    .ie_q      (ie_o),
    .pie_q     (pie_o),
    .pp_q      (pp_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      redirect_o <= 1'b0;
      next_pc_o  <= '0;
      priv_o     <= PRIV_M;
    end else begin
      redirect_o <= take_trap | take_ret;
      if (take_trap) begin
        next_pc_o <= handler_pc;
        priv_o    <= PRIV_M;
      end else if (take_ret) begin
        next_pc_o <= epc_o;
        priv_o    <= pp_o;
      end
    end
  end

  // R10
  redirect_src_chk: assert property (@(posedge clk) disable iff (rst)
    redirect_o |-> $past(trap_req || mret));

  // R9
  collide_chk: assert property (@(posedge clk) disable iff (rst)
    trap_req && mret |=> priv_o == PRIV_M && !ie_o);

  // R7
  ret_pc_chk: assert property (@(posedge clk) disable iff (rst)
    mret && !trap_req |=> next_pc_o == $past(epc_o) && priv_o == $past(pp_o));

  // R3
  trap_pp_chk: assert property (@(posedge clk) disable iff (rst)
    trap_req |=> pp_o == $past(cur_priv) && priv_o == PRIV_M);
endmodule

// File: tb/mtrap_seq_bench.sv
module mtrap_seq_bench;
  localparam int XLEN   = 32;
  localparam int CODE_W = 5;

  logic              clk = 1'b0;
  logic              rst;
  logic              trap_req, trap_irq, mret;
  logic [CODE_W-1:0] trap_code;
  logic [XLEN-1:0]   cur_pc, tvec;
  logic [1:0]        cur_priv;
  logic              redirect_o, ie_o, pie_o;
  logic [XLEN-1:0]   next_pc_o, epc_o, cause_o;
  logic [1:0]        priv_o, pp_o;

  always #2.5 clk = ~clk;

  mtrap_seq #(.XLEN(XLEN), .CODE_W(CODE_W)) u_mtrap_seq (
    .clk(clk), .rst(rst), .trap_req(trap_req), .trap_irq(trap_irq),
    .trap_code(trap_code), .cur_pc(cur_pc), .cur_priv(cur_priv), .mret(mret),
    .tvec(tvec), .redirect_o(redirect_o), .next_pc_o(next_pc_o),
    .priv_o(priv_o), .epc_o(epc_o), .cause_o(cause_o), .ie_o(ie_o),
    .pie_o(pie_o), .pp_o(pp_o)
  );

  typedef struct {
    logic        redir;
    logic [31:0] pc;
    logic [1:0]  priv;
    logic [31:0] epc;
    logic [31:0] cause;
    logic        ie;
    logic        pie;
    logic [1:0]  pp;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   errors = 0;
  int   checks = 0;
  bit   done   = 1'b0;

  // reference model state
  logic [31:0] m_pc = 0, m_epc = 0, m_cause = 0;
  logic [1:0]  m_priv = 2'b11, m_pp = 2'b00;
  logic        m_ie = 0, m_pie = 0;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic op(input logic t, input logic irq, input logic [4:0] code,
                    input logic [31:0] pc, input logic [1:0] cp,
                    input logic r, input logic [31:0] tv, input string tag);
    exp_t e;
    @(negedge clk);
    trap_req = t; trap_irq = irq; trap_code = code; cur_pc = pc;
    cur_priv = cp; mret = r; tvec = tv;
    if (t) begin
      m_epc   = {pc[31:2], 2'b00};
      m_cause = {irq, 26'b0, code};
      m_pie   = m_ie;
      m_ie    = 1'b0;
      m_pp    = cp;
      m_priv  = 2'b11;
      m_pc    = {tv[31:2], 2'b00};
      if (tv[1:0] == 2'b01 && irq) m_pc = m_pc + 32'(code) * 4;
      e.redir = 1'b1;
    end else if (r) begin
      m_pc   = m_epc;
      m_priv = m_pp;
      m_ie   = m_pie;
      m_pie  = 1'b1;
      m_pp   = 2'b00;
      e.redir = 1'b1;
    end else begin
      e.redir = 1'b0;
    end
    e.pc = m_pc; e.priv = m_priv; e.epc = m_epc; e.cause = m_cause;
    e.ie = m_ie; e.pie = m_pie; e.pp = m_pp; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compares one cycle after each driven operation
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk({e.tag, "/R10"}, "redirect", 32'(redirect_o), 32'(e.redir));
      chk(e.tag, "next_pc",  next_pc_o, e.pc);
      chk(e.tag, "priv",     32'(priv_o), 32'(e.priv));
      chk(e.tag, "epc",      epc_o, e.epc);
      chk(e.tag, "cause",    cause_o, e.cause);
      chk(e.tag, "ie",       32'(ie_o), 32'(e.ie));
      chk(e.tag, "pie",      32'(pie_o), 32'(e.pie));
      chk(e.tag, "pp",       32'(pp_o), 32'(e.pp));
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; trap_req = 0; trap_irq = 0; trap_code = 0; cur_pc = 0;
    cur_priv = 0; mret = 0; tvec = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    chk("R10", "rst redirect", 32'(redirect_o), 0);
    chk("R10", "rst priv", 32'(priv_o), 3);
    chk("R10", "rst ie/pie/pp", {29'b0, ie_o, pie_o, pp_o[0] | pp_o[1]}, 0);
    chk("R10", "rst epc", epc_o, 0);
    chk("R10", "rst cause", cause_o, 0);
    chk("R10", "rst next_pc", next_pc_o, 0);
    rst = 1'b0;
    op(0, 0, 0, 32'h0, 2'b00, 0, 32'h0, "R11_idle");
    op(0, 0, 0, 32'h0, 2'b00, 1, 32'h0, "R8_ret1");
    op(0, 0, 0, 32'h0, 2'b00, 1, 32'h0, "R8_ret2");
    // trap with ie=1, direct mode, unaligned pc
    op(1, 1, 5'd7, 32'h1234_5677, 2'b00, 0, 32'h8000_0100, "R1_R2_R3_R4_R5");
    op(0, 0, 0, 32'hFFFF_FFFF, 2'b01, 0, 32'h8000_0101, "R11_hold");
    op(0, 0, 0, 32'h0, 2'b00, 1, 32'h0, "R7_ret_user");
    op(1, 1, 5'd11, 32'h0000_4000, 2'b01, 0, 32'h8000_0201, "R6_vec_irq");
    op(0, 0, 0, 32'h0, 2'b00, 1, 32'h0, "R7_ret_super");
    op(1, 0, 5'd2, 32'h0000_5002, 2'b11, 0, 32'h8000_0201, "R6_vec_exc");
    op(1, 1, 5'd31, 32'h0000_6000, 2'b11, 0, 32'h8000_0301, "R6_vec_max");
    op(1, 1, 5'd0, 32'h0000_6004, 2'b11, 0, 32'h8000_0301, "R6_vec_zero");
    op(1, 1, 5'd9, 32'h0000_7008, 2'b11, 0, 32'h8000_0403, "R5_reserved11");
    op(1, 1, 5'd9, 32'h0000_700C, 2'b01, 0, 32'h8000_0502, "R5_reserved10");
    op(1, 0, 5'd3, 32'h0000_8010, 2'b00, 1, 32'h8000_0600, "R9_collide");
    op(0, 0, 0, 32'h0, 2'b00, 1, 32'h0, "R8_after_collide");
    op(0, 0, 0, 32'h0, 2'b00, 0, 32'h0, "R11_idle2");
    @(negedge clk);
    trap_req = 0; mret = 0;
    repeat (2) @(posedge clk);
    #2;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule